// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block chooses where each operand of a five-stage integer pipeline comes from, so that an instruction can use a result produced by one of the two instructions just ahead of it without waiting for write-back. It compares the two source register numbers of the instruction in the execute stage against the destination registers held in the two pipeline registers that follow. Those are the execute/memory latch and the memory/write-back latch. For each ALU input it returns a 2-bit multiplexer code that picks the register-file value, the execute/memory result or the memory/write-back result.

A third comparison covers stores. When the instruction in the memory stage is a store, its data register is compared with the memory/write-back destination. That result may be ALU output or data read from memory. On a match, a 1-bit select routes that value to the memory write-data port. A dependence three instructions back needs no bypass path, because the register file writes in the first half of a cycle and reads in the second half. Such a source therefore selects the register file.

All selects are registered. The unit is meant to be fed the operand fields one stage early, so that its outputs line up with the execute and memory stages. Load-use stall detection, the register file and the ALU are outside this block.

Top module: `bypass_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, every select output is 0.
- R2: Each select output is registered. It reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R3: A source register that equals a nonzero execute/memory destination whose write enable is 1 gives that operand select code 2'b10.
- R4: A source register that matches a valid memory/write-back destination and no valid execute/memory destination gives select code 2'b01.
- R5: When both the execute/memory and memory/write-back destinations validly match a source, code 2'b10 wins because it is the more recent result.
- R6: A stage whose register-write enable is 0 never supplies a bypass, even if its destination equals the source.
- R7: Register 0 is never bypassed. A source or destination of 0 gives code 2'b00 from that stage.
- R8: The two ALU operand selects are decided independently. Output `alu_a_sel` follows `src_a` and `alu_b_sel` follows `src_b`.
- R9: When the memory-stage instruction is a store and its data register equals a nonzero memory/write-back destination with write enable 1, `st_data_sel` is 1.
- R10: `st_data_sel` is 0 in each of these cases: the memory-stage instruction is not a store, the write-back stage does not match, the data register is 0, or only the execute/memory destination matches.
- R11: A source with no match in either latch, such as a dependence at distance three, gives code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | REG_AW | First source register of the execute-stage instruction |
| src_b | input | REG_AW | Second source register of the execute-stage instruction |
| exm_dst | input | REG_AW | Destination register in the execute/memory latch |
| exm_wen | input | 1 | Register-write enable in the execute/memory latch |
| wb_dst | input | REG_AW | Destination register in the memory/write-back latch |
| wb_wen | input | 1 | Register-write enable in the memory/write-back latch |
| st_src | input | REG_AW | Data register of the memory-stage instruction |
| st_en | input | 1 | Memory-stage instruction is a store |
| alu_a_sel | output | 2 | First ALU input select: 00 register file, 10 execute/memory, 01 memory/write-back |
| alu_b_sel | output | 2 | Second ALU input select, same encoding |
| st_data_sel | output | 1 | 1 routes the memory/write-back value to the store-data port |

## Verification
The operand selects are driven with dependences at distance one, two and three. This separates the 2'b10 path, the 2'b01 path and the register-file default. Patterns in which both latches name the same register test the priority order. Patterns with a cleared write enable or register 0 show that a matching number alone does not trigger a bypass. Mixed patterns give the two operands different sources to show they are decided separately. Store patterns switch the store flag, the write-back match and register 0 one at a time, and include a match in the wrong latch only, so each condition of the store-data select is covered.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_EXM = 2'b10
  } opsrc_e;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              wen,
  output logic              hit
);

  logic nonzero;

  always_comb begin
    nonzero = (dst != '0);
    hit     = wen && nonzero && (dst == src);
  end

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              exm_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output logic [1:0]        sel
);

  logic   hit_exm;
  logic   hit_wb;
  opsrc_e sel_d;
  opsrc_e sel_q;
  logic   run_q;

  fwd_hit #(.REG_AW(REG_AW)) i_hit_exm (
    .src(src), .dst(exm_dst), .wen(exm_wen), .hit(hit_exm)
  );

  fwd_hit #(.REG_AW(REG_AW)) i_hit_wb (
    .src(src), .dst(wb_dst), .wen(wb_wen), .hit(hit_wb)
  );

  always_comb begin
    if (hit_exm)     sel_d = SRC_EXM;
    else if (hit_wb) sel_d = SRC_WB;
    else             sel_d = SRC_RF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SRC_RF;
      run_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      run_q <= 1'b1;
    end
  end

  assign sel = sel_q;

  AST_EXM_WINS: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(exm_wen && (exm_dst == src) && (src != '0))) |-> (sel == 2'b10)); // R5

  AST_WB_ONLY: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(!exm_wen && wb_wen && (wb_dst == src) && (src != '0))) |-> (sel == 2'b01)); // R4

  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(src == '0)) |-> (sel == 2'b00)); // R7

  AST_NO_WEN: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(!exm_wen && !wb_wen)) |-> (sel == 2'b00)); // R6

endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] st_src,
  input  logic              st_en,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output logic              sel
);

  logic hit_wb;
  logic sel_q;
  logic run_q;

  fwd_hit #(.REG_AW(REG_AW)) i_hit_st (
    .src(st_src), .dst(wb_dst), .wen(wb_wen), .hit(hit_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      sel_q <= st_en && hit_wb;
      run_q <= 1'b1;
    end
  end

  assign sel = sel_q;

  AST_ST_OFF: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(!st_en || (st_src == '0))) |-> !sel); // R10

  AST_ST_ON: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(st_en && wb_wen && (wb_dst == st_src) && (st_src != '0))) |-> sel); // R9

endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
  import bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              exm_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic [REG_AW-1:0] st_src,
  input  logic              st_en,
  output logic [1:0]        alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic              st_data_sel
);

  localparam int NOPS = 2;

  logic [REG_AW-1:0] op_src [NOPS];
  logic [1:0]        op_sel [NOPS];

  assign op_src[0] = src_a;
  assign op_src[1] = src_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_operand_sel #(.REG_AW(REG_AW)) i_op (
      .clk     (clk),
      .rst     (rst),
      .src     (op_src[g]),
      .exm_dst (exm_dst),
      .exm_wen (exm_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (op_sel[g])
    );
  end

  fwd_store_sel #(.REG_AW(REG_AW)) i_st (
    .clk    (clk),
    .rst    (rst),
    .st_src (st_src),
    .st_en  (st_en),
    .wb_dst (wb_dst),
    .wb_wen (wb_wen),
    .sel    (st_data_sel)
  );

  assign alu_a_sel = op_sel[0];
  assign alu_b_sel = op_sel[1];

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_SEL_CODE: assert (alu_a_sel != 2'b11 && alu_b_sel != 2'b11); // R3
    end
  end

  AST_STABLE_IN_RESET: assert property (@(posedge clk)
    $past(rst) |-> (alu_a_sel == 2'b00 && alu_b_sel == 2'b00 && !st_data_sel)); // R1

endmodule

// File: tb/test_bypass_unit.sv
module test_bypass_unit;

  localparam int AW    = 5;
  localparam int NVEC  = 14;
  localparam int VEC_W = 33;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] src_a, src_b, exm_dst, wb_dst, st_src;
  logic          exm_wen, wb_wen, st_en;
  logic [1:0]    alu_a_sel, alu_b_sel;
  logic          st_data_sel;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bypass_unit #(.REG_AW(AW)) i_bypass_unit (
    .clk(clk), .rst(rst),
    .src_a(src_a), .src_b(src_b),
    .exm_dst(exm_dst), .exm_wen(exm_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .st_src(st_src), .st_en(st_en),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .st_data_sel(st_data_sel)
  );

  // fields: src_a, src_b, exm_dst, exm_wen, wb_dst, wb_wen, st_src, st_en, exp_a, exp_b, exp_st
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R11 distance 3
    {5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0}, // R3 distance 1
    {5'd2, 5'd3, 5'd3, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0}, // R8
    {5'd4, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 2'b01, 2'b01, 1'b0}, // R4 distance 2
    {5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 2'b10, 2'b10, 1'b0}, // R5 chain
    {5'd5, 5'd6, 5'd5, 1'b0, 5'd5, 1'b1, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0}, // R6
    {5'd5, 5'd6, 5'd5, 1'b0, 5'd5, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R6
    {5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R7
    {5'd7, 5'd8, 5'd8, 1'b1, 5'd7, 1'b1, 5'd0, 1'b0, 2'b01, 2'b10, 1'b0}, // R8
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 5'd9, 1'b1, 2'b00, 2'b00, 1'b1}, // R9
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 5'd9, 1'b0, 2'b00, 2'b00, 1'b0}, // R10 not a store
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b0, 5'd9, 1'b1, 2'b00, 2'b00, 1'b0}, // R10 no write
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0}, // R10 register 0
    {5'd1, 5'd2, 5'd9, 1'b1, 5'd4, 1'b1, 5'd9, 1'b1, 2'b00, 2'b00, 1'b0}  // R10 wrong latch
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got a/b/st=%b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [VEC_W-1:0] v);
    src_a   = v[32:28];
    src_b   = v[27:23];
    exm_dst = v[22:18];
    exm_wen = v[17];
    wb_dst  = v[16:12];
    wb_wen  = v[11];
    st_src  = v[10:6];
    st_en   = v[5];
  endtask

  initial begin
    rst = 1'b1;
    drive(VEC[4]);
    repeat (3) @(negedge clk);
    check("R1 during reset", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b00000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b10100);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("vector %0d (R3-R11 table)", i),
            {alu_a_sel, alu_b_sel, st_data_sel}, VEC[i][4:0]);
    end

    // R2: a new input does not reach the outputs before the next edge
    drive(VEC[4]);
    @(negedge clk);
    drive(VEC[0]);
    #2;
    check("R2 hold before edge", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b10100);
    @(negedge clk);
    check("R2 update after edge", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b00000);

    // R9 then R1: reset mid-run clears a live store select
    drive(VEC[9]);
    @(negedge clk);
    check("R9 store bypass", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b00001);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b00000);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule